// File: doc/BRIEF.md
# Tagged Reselection Message Sequencer

This block runs the message-in part of a bus-initiated selection or reselection on a parallel SCSI-style bus. Once the host has armed it, a reselection request makes it store the raw bus ID byte in a receive FIFO. It then fetches message bytes over a per-byte request / valid / acknowledge handshake. After the first (identify) byte, it samples the attention line. From that sample and the configuration, it decides one of three things: finish after one byte, fetch a two-byte queue-tag message, or abort.

A queue-tag message is a tag code followed by a tag value. The tag code is checked against a small legal range. The tag value is taken as it comes. Every ending loads a status code and raises an interrupt. A normal ending also pulses a signal that tells the phase logic to move on to the command phase. The host drains the FIFO through a first-word-fall-through read port. Reading the status clears both the status and the interrupt.

Three-byte mode is on when either of two host configuration bits is set. The two bits are ORed, so either one alone is enough.

Top module: `resel_msg_seq`

## Requirements
- R1: After reset, msg_req, msg_ack, irq and cmd_go are low, stat_code is 0 (none), fifo_empty is high and fifo_count is 0.
- R2: A reselection request is taken only when the block is idle and armed by an earlier en_cmd pulse. Arming is used up by one accepted reselection. An unarmed request leaves msg_req low, the FIFO unchanged and irq low. The bus ID byte is the first byte written to the FIFO.
- R3: msg_req stays high until msg_vld is seen. msg_ack is high for exactly the one cycle after the byte is captured, and only then.
- R4: If attention is low in the cycle after the first byte's acknowledge, the sequence ends with status 1 (one byte), a one-cycle cmd_go pulse, and the FIFO holding bus ID then identify byte.
- R5: Three-byte mode is enabled when the extended-message bit or the queue-tag bit is set, each bit alone being enough.
- R6: If attention is high after the first byte and three-byte mode is on, two more bytes are fetched. The middle one must be 0x20, 0x21 or 0x22, and the last one may be any value. The sequence ends with status 2, a cmd_go pulse, and the FIFO order bus ID, identify, tag code, tag value.
- R7: A middle byte outside 0x20..0x22 ends the sequence after its acknowledge with status 3 and no cmd_go. The bad byte is not stored and no third byte is requested.
- R8: If attention is high after the first byte and three-byte mode is off, the sequence ends with status 4 (aborted) and no cmd_go.
- R9: A stat_rd pulse clears stat_code to 0 and drops irq at the next edge.
- R10: The FIFO returns bytes in write order, reports empty and count, and ignores a pop when empty. Its count never exceeds FIFO_DEPTH (16).
- R11: An en_cmd pulse while idle empties the FIFO. An en_cmd pulse during a sequence has no effect: the FIFO is not cleared and the block is not re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_msg_wr | input | 1 | Write strobe for the extended-message enable bit |
| ext_msg_wdata | input | 1 | Value for the extended-message enable bit |
| qtag_wr | input | 1 | Write strobe for the queue-tag enable bit |
| qtag_wdata | input | 1 | Value for the queue-tag enable bit |
| en_cmd | input | 1 | Enable selection/reselection command pulse |
| resel_req | input | 1 | Reselection detected on the bus |
| bus_id | input | 8 | Raw bus state captured during reselection |
| msg_req | output | 1 | Request for the next message byte |
| msg_vld | input | 1 | Incoming message byte is valid |
| msg_byte | input | 8 | Incoming message byte |
| msg_ack | output | 1 | One-cycle acknowledge of a captured byte |
| atn | input | 1 | Attention line |
| cmd_go | output | 1 | One-cycle pulse: proceed to command phase |
| irq | output | 1 | Interrupt, high while a status is pending |
| stat_rd | input | 1 | Status read strobe (clears status and irq) |
| stat_code | output | 3 | 0 none, 1 one byte, 2 three bytes, 3 bad tag, 4 aborted |
| fifo_pop | input | 1 | Remove the head byte of the FIFO |
| fifo_data | output | 8 | FIFO head byte |
| fifo_empty | output | 1 | FIFO is empty |
| fifo_count | output | 5 | Bytes held in the FIFO |

## Verification
An accepted reselection raises msg_req one edge later, and the bus ID byte enters the FIFO at that same edge. A byte strobed at one edge is acknowledged during the following cycle. Attention is judged in the cycle after that. The status code, irq and cmd_go all register together at the end of that judging cycle, two edges after the last byte is captured. A status read or an idle enable command takes effect at the next edge.

The bench drives every input on the falling edge and samples every output on later falling edges. It counts acknowledge cycles while serving the handshake. It compares the status code, cmd_go and the FIFO contents, drained byte by byte, against a bench model of the attention and configuration rules.

// File: rtl/resel_pkg.sv
package resel_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_ACK  = 2'd2,
    SQ_CHK  = 2'd3
  } sq_state_e;

  typedef enum logic [2:0] {
    FIN_NONE   = 3'd0,
    FIN_ONE    = 3'd1,
    FIN_THREE  = 3'd2,
    FIN_BADTAG = 3'd3,
    FIN_ABORT  = 3'd4
  } fin_code_e;

endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic [CW-1:0] count
);

  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_n = (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  // R10: occupancy bounded by the depth
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R10: pop of an empty FIFO leaves it empty
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/tag_check.sv
module tag_check #(
  parameter int W               = 8,
  parameter logic [W-1:0] LO    = 8'h20,
  parameter logic [W-1:0] HI    = 8'h22
) (
  input  logic [W-1:0] code,
  output logic         legal
);

  always_comb begin
    legal = (code >= LO) && (code <= HI);
  end

endmodule

// File: rtl/stat_hold.sv
module stat_hold
  import resel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fin_vld,
  input  fin_code_e fin_code,
  input  logic      rd,
  output logic [2:0] code,
  output logic      irq
);

  fin_code_e code_q, code_n;
  logic      irq_q, irq_n;

  always_comb begin
    code_n = code_q;
    irq_n  = irq_q;
    if (fin_vld) begin
      code_n = fin_code;
      irq_n  = 1'b1;
    end else if (rd) begin
      code_n = FIN_NONE;
      irq_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= FIN_NONE;
      irq_q  <= 1'b0;
    end else begin
      code_q <= code_n;
      irq_q  <= irq_n;
    end
  end

  assign code = code_q;
  assign irq  = irq_q;

  // R9: a read with no new ending drops the interrupt
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !fin_vld) |=> (!irq && code == 3'd0));

endmodule

// File: rtl/resel_msg_seq.sv
module resel_msg_seq
  import resel_pkg::*;
#(
  parameter int FIFO_DEPTH          = 16,
  parameter logic [7:0] TAG_CODE_LO = 8'h20,
  parameter logic [7:0] TAG_CODE_HI = 8'h22,
  localparam int CNT_W              = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_msg_wr,
  input  logic             ext_msg_wdata,
  input  logic             qtag_wr,
  input  logic             qtag_wdata,
  input  logic             en_cmd,
  input  logic             resel_req,
  input  logic [7:0]       bus_id,
  output logic             msg_req,
  input  logic             msg_vld,
  input  logic [7:0]       msg_byte,
  output logic             msg_ack,
  input  logic             atn,
  output logic             cmd_go,
  output logic             irq,
  input  logic             stat_rd,
  output logic [2:0]       stat_code,
  input  logic             fifo_pop,
  output logic [7:0]       fifo_data,
  output logic             fifo_empty,
  output logic [CNT_W-1:0] fifo_count
);

  localparam logic [1:0] IDX_ID  = 2'd0;
  localparam logic [1:0] IDX_TAG = 2'd1;
  localparam logic [1:0] IDX_VAL = 2'd2;

  sq_state_e   state_q, state_n;
  logic [1:0]  idx_q, idx_n;
  logic        bad_q, bad_n;
  logic        armed_q, armed_n;
  logic        ext_q, qtag_q;
  logic        go_q, go_n;
  logic        wide_mode, tag_ok;
  logic        push, clr, fin;
  logic [7:0]  push_data;
  fin_code_e   fin_code;

  assign wide_mode = ext_q | qtag_q;

  tag_check #(.W(BYTE_W), .LO(TAG_CODE_LO), .HI(TAG_CODE_HI)) u_tag (
    .code  (msg_byte),
    .legal (tag_ok)
  );

  always_comb begin
    state_n   = state_q;
    idx_n     = idx_q;
    bad_n     = bad_q;
    armed_n   = armed_q;
    push      = 1'b0;
    push_data = msg_byte;
    clr       = 1'b0;
    fin       = 1'b0;
    fin_code  = FIN_NONE;
    msg_req   = 1'b0;
    msg_ack   = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (en_cmd) begin
          clr     = 1'b1;
          armed_n = 1'b1;
        end else if (resel_req && armed_q) begin
          push      = 1'b1;
          push_data = bus_id;
          armed_n   = 1'b0;
          idx_n     = IDX_ID;
          bad_n     = 1'b0;
          state_n   = SQ_REQ;
        end
      end
      SQ_REQ: begin
        msg_req = 1'b1;
        if (msg_vld) begin
          bad_n   = (idx_q == IDX_TAG) && !tag_ok;
          push    = !((idx_q == IDX_TAG) && !tag_ok);
          state_n = SQ_ACK;
        end
      end
      SQ_ACK: begin
        msg_ack = 1'b1;
        state_n = SQ_CHK;
      end
      default: begin
        state_n = SQ_IDLE;
        case (idx_q)
          IDX_ID: begin
            if (!atn) begin
              fin      = 1'b1;
              fin_code = FIN_ONE;
            end else if (wide_mode) begin
              idx_n   = IDX_TAG;
              state_n = SQ_REQ;
            end else begin
              fin      = 1'b1;
              fin_code = FIN_ABORT;
            end
          end
          IDX_TAG: begin
            if (bad_q) begin
              fin      = 1'b1;
              fin_code = FIN_BADTAG;
            end else begin
              idx_n   = IDX_VAL;
              state_n = SQ_REQ;
            end
          end
          default: begin
            fin      = 1'b1;
            fin_code = FIN_THREE;
          end
        endcase
      end
    endcase
    go_n = fin && ((fin_code == FIN_ONE) || (fin_code == FIN_THREE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= IDX_ID;
      bad_q   <= 1'b0;
      armed_q <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      bad_q   <= bad_n;
      armed_q <= armed_n;
      go_q    <= go_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      qtag_q <= 1'b0;
    end else begin
      if (ext_msg_wr) ext_q  <= ext_msg_wdata;
      if (qtag_wr)    qtag_q <= qtag_wdata;
    end
  end

  assign cmd_go = go_q;

  msg_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .push  (push),
    .din   (push_data),
    .pop   (fifo_pop),
    .dout  (fifo_data),
    .empty (fifo_empty),
    .count (fifo_count)
  );

  stat_hold u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_vld  (fin),
    .fin_code (fin_code),
    .rd       (stat_rd),
    .code     (stat_code),
    .irq      (irq)
  );

  // R3: acknowledge only right after a captured byte, and for one cycle
  assert_ack_after_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ack |-> $past(msg_req && msg_vld));
  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ack |=> !msg_ack);

  // R2: unarmed reselection leaves the sequencer idle and the FIFO alone
  assert_unarmed_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && resel_req && !armed_q && !en_cmd && !fifo_pop)
      |=> (state_q == SQ_IDLE && fifo_count == $past(fifo_count)));

  // R8: an abort only happens with three-byte mode off
  assert_abort_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && stat_code == 3'd4) |-> $past(!wide_mode));

  // R4: proceeding to command phase comes with a pending interrupt
  assert_go_with_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (irq && (stat_code == 3'd1 || stat_code == 3'd2)));

endmodule

// File: tb/resel_msg_seq_test.sv
module resel_msg_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_msg_wr, ext_msg_wdata, qtag_wr, qtag_wdata;
  logic       en_cmd, resel_req;
  logic [7:0] bus_id;
  logic       msg_req, msg_vld, msg_ack, atn, cmd_go, irq, stat_rd;
  logic [7:0] msg_byte;
  logic [2:0] stat_code;
  logic       fifo_pop;
  logic [7:0] fifo_data;
  logic       fifo_empty;
  logic [4:0] fifo_count;

  int checks = 0;
  int fails  = 0;
  bit cfg_ext = 0;
  bit cfg_qt  = 0;
  bit over    = 0;

  always #4 clk = ~clk;

  resel_msg_seq uut (
    .clk(clk), .rst_n(rst_n),
    .ext_msg_wr(ext_msg_wr), .ext_msg_wdata(ext_msg_wdata),
    .qtag_wr(qtag_wr), .qtag_wdata(qtag_wdata),
    .en_cmd(en_cmd), .resel_req(resel_req), .bus_id(bus_id),
    .msg_req(msg_req), .msg_vld(msg_vld), .msg_byte(msg_byte),
    .msg_ack(msg_ack), .atn(atn), .cmd_go(cmd_go), .irq(irq),
    .stat_rd(stat_rd), .stat_code(stat_code),
    .fifo_pop(fifo_pop), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_count(fifo_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input bit a0, input bit wide, input logic [7:0] mid);
    if (!a0) return 1;
    if (!wide) return 4;
    if (mid < 8'h20 || mid > 8'h22) return 3;
    return 2;
  endfunction

  function automatic int exp_acks(input int code);
    case (code)
      1, 4:    return 1;
      3:       return 2;
      default: return 3;
    endcase
  endfunction

  task automatic set_cfg(input bit e, input bit q);
    @(negedge clk);
    ext_msg_wr = 1; ext_msg_wdata = e; qtag_wr = 1; qtag_wdata = q;
    @(negedge clk);
    ext_msg_wr = 0; qtag_wr = 0;
    cfg_ext = e; cfg_qt = q;
  endtask

  task automatic pulse_en();
    @(negedge clk);
    en_cmd = 1;
    @(negedge clk);
    en_cmd = 0;
  endtask

  task automatic read_stat(input string req);
    @(negedge clk);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    chk(stat_code == 3'd0, req, int'(stat_code), 0);
    chk(irq == 1'b0, req, int'(irq), 0);
  endtask

  task automatic pop_expect(input logic [7:0] v, input string req);
    chk(fifo_data == v, req, int'(fifo_data), int'(v));
    fifo_pop = 1;
    @(negedge clk);
    fifo_pop = 0;
  endtask

  // one whole sequence: arm, reselect, serve bytes, check outcome
  task automatic run_seq(input logic [7:0] id, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input bit a0, input bit poke, input string tag);
    int code, acks, k;
    bit go;
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    code = exp_code(a0, cfg_ext | cfg_qt, b1);
    acks = 0; k = 0; go = 0;
    pulse_en();
    resel_req = 1; bus_id = id;
    @(negedge clk);
    resel_req = 0;
    for (int cyc = 0; cyc < 60; cyc++) begin
      en_cmd = 0;
      if (msg_ack) acks++;
      if (cmd_go) go = 1;
      if (irq) break;
      if (msg_vld) msg_vld = 0;
      else if (msg_req && k < 3) begin
        msg_vld = 1; msg_byte = bytes[k];
        atn = (k == 0) ? a0 : 1'b0;
        if (poke && k == 0) en_cmd = 1;
        k++;
      end
      @(negedge clk);
    end
    en_cmd = 0;
    chk(irq == 1'b1, {tag, " R3 irq at end"}, int'(irq), 1);
    chk(int'(stat_code) == code, {tag, " R4 R6 R7 R8 status"}, int'(stat_code), code);
    chk(acks == exp_acks(code), {tag, " R3 ack count"}, acks, exp_acks(code));
    chk(go == (code == 1 || code == 2), {tag, " R4 R6 cmd_go"}, int'(go), int'(code == 1 || code == 2));
    chk(int'(fifo_count) == ((code == 2) ? 4 : 2), {tag, " R2 R7 R11 fifo count"},
        int'(fifo_count), (code == 2) ? 4 : 2);
    pop_expect(id, {tag, " R2 bus id first"});
    pop_expect(b0, {tag, " R10 identify"});
    if (code == 2) begin
      pop_expect(b1, {tag, " R6 tag code"});
      pop_expect(b2, {tag, " R6 tag value"});
    end
    chk(fifo_empty == 1'b1, {tag, " R10 drained"}, int'(fifo_empty), 1);
    read_stat({tag, " R9"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!over) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    ext_msg_wr = 0; ext_msg_wdata = 0; qtag_wr = 0; qtag_wdata = 0;
    en_cmd = 0; resel_req = 0; bus_id = 0; msg_vld = 0; msg_byte = 0;
    atn = 0; stat_rd = 0; fifo_pop = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(msg_req == 0 && msg_ack == 0, "R1 handshake idle", int'({msg_req, msg_ack}), 0);
    chk(irq == 0 && cmd_go == 0, "R1 irq/cmd_go", int'({irq, cmd_go}), 0);
    chk(stat_code == 0, "R1 status", int'(stat_code), 0);
    chk(fifo_empty == 1 && fifo_count == 0, "R1 fifo", int'(fifo_count), 0);

    // R2 unarmed reselection ignored
    resel_req = 1; bus_id = 8'h81;
    @(negedge clk);
    resel_req = 0;
    repeat (3) @(negedge clk);
    chk(msg_req == 0, "R2 unarmed no request", int'(msg_req), 0);
    chk(fifo_count == 0, "R2 unarmed fifo", int'(fifo_count), 0);
    chk(irq == 0, "R2 unarmed irq", int'(irq), 0);

    // R10 pop on empty ignored
    @(negedge clk); fifo_pop = 1;
    @(negedge clk); fifo_pop = 0;
    chk(fifo_empty == 1 && fifo_count == 0, "R10 empty pop", int'(fifo_count), 0);

    // directed sequences
    set_cfg(0, 0);
    run_seq(8'h41, 8'hC0, 8'h20, 8'h05, 0, 0, "one-byte");
    run_seq(8'h42, 8'hC1, 8'h20, 8'h05, 1, 0, "R8 narrow abort");
    // R2 arming consumed by the accepted sequence
    resel_req = 1; bus_id = 8'h44;
    @(negedge clk);
    resel_req = 0;
    repeat (3) @(negedge clk);
    chk(msg_req == 0 && fifo_count == 0, "R2 one-shot arming", int'(fifo_count), 0);
    set_cfg(1, 0);
    run_seq(8'h48, 8'hC2, 8'h20, 8'h00, 1, 0, "R5 ext bit low code");
    set_cfg(0, 1);
    run_seq(8'h50, 8'hC3, 8'h22, 8'hFF, 1, 0, "R5 qtag bit high code");
    run_seq(8'h60, 8'hC4, 8'h21, 8'h7E, 0, 0, "R4 wide but atn low");
    run_seq(8'h61, 8'hC5, 8'h23, 8'h11, 1, 0, "R7 code above");
    set_cfg(1, 1);
    run_seq(8'h62, 8'hC6, 8'h1F, 8'h11, 1, 0, "R7 code below");
    run_seq(8'h63, 8'hC7, 8'h21, 8'h33, 1, 1, "R11 enable while busy");
    // R11 busy enable did not re-arm
    resel_req = 1; bus_id = 8'h66;
    @(negedge clk);
    resel_req = 0;
    repeat (3) @(negedge clk);
    chk(msg_req == 0 && fifo_count == 0, "R11 busy enable not armed", int'(fifo_count), 0);

    // R11 idle enable clears fifo: leave bytes, then clear
    pulse_en();
    resel_req = 1; bus_id = 8'h70;
    @(negedge clk);
    resel_req = 0;
    chk(fifo_count == 1, "R11 bus id stored", int'(fifo_count), 1);
    msg_vld = 1; msg_byte = 8'hC0; atn = 0;
    @(negedge clk); msg_vld = 0;
    repeat (3) @(negedge clk);
    chk(irq == 1 && fifo_count == 2, "R4 pending before clear", int'(fifo_count), 2);
    pulse_en();
    chk(fifo_count == 0 && fifo_empty == 1, "R11 idle enable clears", int'(fifo_count), 0);
    read_stat("R9 after clear");

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      logic [7:0] mid;
      mid = ($urandom % 2 == 0) ? 8'(8'h20 + $urandom % 3) : 8'($urandom);
      set_cfg(1'($urandom), 1'($urandom));
      run_seq(8'($urandom), 8'($urandom), mid, 8'($urandom), 1'($urandom), 1'($urandom),
              "random");
    end

    over = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule